// File: doc/BRIEF.md
# GF(4) Min-Max Parity Check Update

This block performs the check-side update of a min-max iterative decoder for a non-binary low-density parity-check code over the four-element field. One parity check connects `DEG` variable nodes, and each connection carries a nonzero field coefficient. Every incoming message is a vector of four reliability costs, one per field symbol, where a smaller value means the symbol is more likely.

For every edge and every candidate symbol, the block searches the symbol choices of the *other* edges that satisfy the parity equation together with that candidate. For each such choice it scores the largest cost involved. It then reports the smallest of those scores. The search uses a forward-backward chain of pairwise min-max merges, so the logic grows linearly with the degree. The caller presents all messages and coefficients together with a one-cycle `start_i`. All `DEG` outgoing vectors appear together one cycle later, marked by `done_o`.

Top module: `gf4_minmax_check_node`

## Requirements
- R1: While `rst_n` is low, `msg_o` is all zeros and `done_o` is low.
- R2: `done_o` is high for exactly the one cycle after each cycle in which `start_i` is high, and is low otherwise.
- R3: The output for edge n and symbol a is the minimum, over every assignment of symbols x_k to the other edges k≠n with h_n·a + Σ h_k·x_k = 0, of the maximum of the input costs L_k(x_k) of those other edges.
- R4: The output vector of edge n does not depend on the input vector of edge n.
- R5: Symbols are 2-bit polynomial coefficients (bit 1 weights α, bit 0 weights 1). Addition is bitwise XOR. Multiplication reduces modulo α²+α+1, so α·α = 3 and α·3 = 1. Each coefficient field `coef_i[2n+1:2n]` must be nonzero while `start_i` is high.
- R6: Edge n's cost for symbol i sits at bits `[(4n+i)*W +: W]` of both `msg_i` and `msg_o`.
- R7: Between start strobes, `msg_o` holds its value even when `msg_i` and `coef_i` change.
- R8: For every edge, the smallest of its four output costs equals the largest, over the other edges, of each one's smallest input cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture strobe for one check update |
| coef_i | input | 2*DEG | Nonzero edge coefficients, 2 bits per edge |
| msg_i | input | DEG*4*W | Incoming cost vectors, packed per R6 |
| msg_o | output | DEG*4*W | Outgoing cost vectors, packed per R6 |
| done_o | output | 1 | Result valid strobe |

## Verification
The assertions assume that every coefficient is nonzero whenever `start_i` is high, because a zero coefficient has no inverse and would break the symbol permutation. The assertions also take `start_i` as a level the caller raises for single cycles. The bench draws coefficients only from 1 to 3 and drives each start as a one-cycle pulse. It compares every result against an exhaustive enumeration of all symbol assignments that satisfy the parity equation. The directed cases pin down the field arithmetic and the bit packing.

// File: rtl/gf4_mm_pkg.sv
package gf4_mm_pkg;

  localparam int unsigned Q = 4;

  function automatic logic [1:0] gf4_log(input logic [1:0] s);
    case (s)
      2'd2:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] gf4_exp(input logic [1:0] e);
    case (e)
      2'd1:    return 2'd2;
      2'd2:    return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  // product of two field symbols through the log/antilog form
  function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] e;
    if (a == 2'd0 || b == 2'd0) return 2'd0;
    e = {1'b0, gf4_log(a)} + {1'b0, gf4_log(b)};
    if (e >= 3'd3) e = e - 3'd3;
    return gf4_exp(e[1:0]);
  endfunction

  function automatic logic [1:0] gf4_inv(input logic [1:0] a);
    case (a)
      2'd2:    return 2'd3;
      2'd3:    return 2'd2;
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/gf4_coef_perm.sv
module gf4_coef_perm
  import gf4_mm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [1:0]     coef_i,
  input  logic [Q*W-1:0] vec_i,
  output logic [Q*W-1:0] vec_o
);
  // entry y of the output holds the cost of the symbol x with coef*x = y
  logic [1:0] inv_c;
  assign inv_c = gf4_inv(coef_i);

  always_comb begin
    vec_o = '0;
    for (int y = 0; y < Q; y++) begin
      vec_o[y*W +: W] = vec_i[int'(gf4_mul(2'(y), inv_c))*W +: W];
    end
  end
endmodule

// File: rtl/gf4_mm_combine.sv
module gf4_mm_combine
  import gf4_mm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [Q*W-1:0] a_i,
  input  logic [Q*W-1:0] b_i,
  output logic [Q*W-1:0] c_o
);
  // c[s] = min over x of max(a[x], b[x ^ s])
  always_comb begin
    logic [W-1:0] best, cand, av, bv;
    c_o = '0;
    for (int s = 0; s < Q; s++) begin
      best = '1;
      for (int x = 0; x < Q; x++) begin
        av   = a_i[x*W +: W];
        bv   = b_i[(x ^ s)*W +: W];
        cand = (av > bv) ? av : bv;
        if (cand < best) best = cand;
      end
      c_o[s*W +: W] = best;
    end
  end

  // R3: pairing symbol 0 of a with symbol s of b is one valid pair, so it bounds the result
  always_comb begin
    for (int s = 0; s < Q; s++) begin
      assert_pair_bound_R3: assert (c_o[s*W +: W] <=
        ((a_i[W-1:0] > b_i[s*W +: W]) ? a_i[W-1:0] : b_i[s*W +: W]));
    end
  end
endmodule

// File: rtl/gf4_minmax_check_node.sv
module gf4_minmax_check_node
  import gf4_mm_pkg::*;
#(
  parameter int unsigned DEG = 6,
  parameter int unsigned W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [2*DEG-1:0]     coef_i,
  input  logic [DEG*Q*W-1:0]   msg_i,
  output logic [DEG*Q*W-1:0]   msg_o,
  output logic                 done_o
);
  localparam int unsigned VW = Q * W;

  logic [VW-1:0]      perm [DEG];
  logic [VW-1:0]      fwd  [DEG];
  logic [VW-1:0]      bwd  [DEG];
  logic [VW-1:0]      ext  [DEG];
  logic [DEG*VW-1:0]  res_flat;
  logic [DEG*VW-1:0]  msg_q;
  logic               done_q;

  // edge vectors mapped onto the product domain h_k * x_k
  for (genvar k = 0; k < DEG; k++) begin : g_perm
    gf4_coef_perm #(.W(W)) u_perm (
      .coef_i (coef_i[2*k +: 2]),
      .vec_i  (msg_i[k*VW +: VW]),
      .vec_o  (perm[k])
    );
  end

  // forward chain over edges 0..k, backward chain over edges k..DEG-1
  assign fwd[0]     = perm[0];
  assign bwd[DEG-1] = perm[DEG-1];
  for (genvar k = 1; k < DEG; k++) begin : g_fwd
    gf4_mm_combine #(.W(W)) u_f (.a_i(fwd[k-1]), .b_i(perm[k]), .c_o(fwd[k]));
  end
  for (genvar k = 0; k < DEG - 1; k++) begin : g_bwd
    gf4_mm_combine #(.W(W)) u_b (.a_i(perm[k]), .b_i(bwd[k+1]), .c_o(bwd[k]));
  end

  // extrinsic merge excluding the edge itself
  for (genvar n = 0; n < DEG; n++) begin : g_ext
    if (n == 0) begin : g_first
      assign ext[n] = bwd[1];
    end else if (n == DEG - 1) begin : g_last
      assign ext[n] = fwd[DEG-2];
    end else begin : g_mid
      gf4_mm_combine #(.W(W)) u_e (.a_i(fwd[n-1]), .b_i(bwd[n+1]), .c_o(ext[n]));
    end
  end

  // candidate a on edge n needs the others to sum to h_n * a
  always_comb begin
    res_flat = '0;
    for (int n = 0; n < DEG; n++) begin
      for (int a = 0; a < Q; a++) begin
        res_flat[n*VW + a*W +: W] =
          ext[n][int'(gf4_mul(coef_i[2*n +: 2], 2'(a)))*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) msg_q <= res_flat;
    end
  end

  assign msg_o  = msg_q;
  assign done_o = done_q;

  // ---------------- assertions ----------------
  function automatic logic [W-1:0] vmin(input logic [VW-1:0] v);
    logic [W-1:0] m;
    m = v[W-1:0];
    for (int i = 1; i < Q; i++) if (v[i*W +: W] < m) m = v[i*W +: W];
    return m;
  endfunction

  logic [W-1:0] floor_in [DEG];
  always_comb begin
    for (int n = 0; n < DEG; n++) begin
      floor_in[n] = '0;
      for (int k = 0; k < DEG; k++) begin
        if (k != n && vmin(msg_i[k*VW +: VW]) > floor_in[n])
          floor_in[n] = vmin(msg_i[k*VW +: VW]);
      end
    end
  end

  assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i));

  assert_hold_between_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(msg_o));

  for (genvar n = 0; n < DEG; n++) begin : g_chk
    assert_coef_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> coef_i[2*n +: 2] != 2'd0);

    assert_floor_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> vmin(msg_o[n*VW +: VW]) == $past(floor_in[n]));
  end
endmodule

// File: tb/gf4_minmax_check_node_tb_top.sv
module gf4_minmax_check_node_tb_top;
  localparam int DEG = 6;
  localparam int W   = 8;
  localparam int VW  = 4 * W;
  localparam int TW  = DEG * VW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [2*DEG-1:0] coef_i = '0;
  logic [TW-1:0] msg_i = '0;
  logic [TW-1:0] msg_o;
  logic          done_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [TW-1:0] exp_q[$];

  always #5 clk = ~clk;

  gf4_minmax_check_node #(.DEG(DEG), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .coef_i(coef_i),
    .msg_i(msg_i), .msg_o(msg_o), .done_o(done_o)
  );

  // field product by shift and reduce with a^2 = a + 1
  function automatic logic [1:0] ref_mul(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] p;
    p = 3'd0;
    if (b[0]) p = p ^ {1'b0, a};
    if (b[1]) p = p ^ {a, 1'b0};
    if (p[2]) p = p ^ 3'b111;
    return p[1:0];
  endfunction

  // exhaustive reference over every valid assignment
  function automatic logic [TW-1:0] ref_model(input logic [2*DEG-1:0] c, input logic [TW-1:0] m);
    logic [TW-1:0] r;
    r = '1;
    for (int cfg = 0; cfg < (1 << (2*DEG)); cfg++) begin
      logic [1:0] sum;
      sum = 2'd0;
      for (int k = 0; k < DEG; k++) sum = sum ^ ref_mul(c[2*k +: 2], 2'(cfg >> (2*k)));
      if (sum == 2'd0) begin
        for (int n = 0; n < DEG; n++) begin
          logic [W-1:0] mx;
          int xn;
          mx = '0;
          for (int k = 0; k < DEG; k++) begin
            if (k != n) begin
              logic [W-1:0] v;
              v = m[k*VW + ((cfg >> (2*k)) & 3)*W +: W];
              if (v > mx) mx = v;
            end
          end
          xn = (cfg >> (2*n)) & 3;
          if (mx < r[n*VW + xn*W +: W]) r[n*VW + xn*W +: W] = mx;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [TW-1:0] act,
                       input logic [TW-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // driver: push expected result, pulse start for one cycle
  task automatic send(input logic [2*DEG-1:0] c, input logic [TW-1:0] m);
    exp_q.push_back(ref_model(c, m));
    @(negedge clk);
    coef_i  = c;
    msg_i   = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor: pop and compare per edge on each done
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check("R2", "done without start", {{(TW-1){1'b0}}, done_o}, '0);
      end else begin
        logic [TW-1:0] e;
        e = exp_q.pop_front();
        for (int n = 0; n < DEG; n++)
          check("R3", $sformatf("edge %0d", n), TW'(msg_o[n*VW +: VW]), TW'(e[n*VW +: VW]));
      end
    end
  end

  function automatic logic [VW-1:0] vec(input int s0, input int s1, input int s2, input int s3);
    return {W'(s3), W'(s2), W'(s1), W'(s0)};
  endfunction

  function automatic logic [TW-1:0] rand_msg();
    logic [TW-1:0] m;
    for (int i = 0; i < TW / 32; i++) m[i*32 +: 32] = $urandom;
    return m;
  endfunction

  function automatic logic [2*DEG-1:0] rand_coef();
    logic [2*DEG-1:0] c;
    for (int k = 0; k < DEG; k++) c[2*k +: 2] = 2'(1 + ($urandom % 3));
    return c;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] m, snap, o_a;
    logic [2*DEG-1:0] c;

    repeat (3) @(negedge clk);
    check("R1", "msg_o in reset", msg_o, '0);
    check("R1", "done_o in reset", TW'(done_o), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "done idle", TW'(done_o), '0);

    // R6: all coefficients 1; edge 1 prefers symbol 3, others prefer 0
    m = '0;
    for (int k = 0; k < DEG; k++) m[k*VW +: VW] = vec(0, 100, 100, 100);
    m[1*VW +: VW] = vec(100, 100, 100, 0);
    c = {DEG{2'd1}};
    send(c, m);
    check("R6", "edge0 sym3", TW'(msg_o[3*W +: W]), TW'(0));
    check("R6", "edge0 sym1", TW'(msg_o[1*W +: W]), TW'(100));
    @(negedge clk);
    check("R2", "done one cycle", TW'(done_o), '0);

    // R5: edge0 coefficient alpha, edge1 prefers 1 -> alpha*a = 1 -> a = 3
    m = '0;
    for (int k = 0; k < DEG; k++) m[k*VW +: VW] = vec(0, 100, 100, 100);
    m[1*VW +: VW] = vec(100, 0, 100, 100);
    c = {{(DEG-1){2'd1}}, 2'd2};
    send(c, m);
    check("R5", "edge0 sym3", TW'(msg_o[3*W +: W]), TW'(0));
    check("R5", "edge0 sym1", TW'(msg_o[1*W +: W]), TW'(100));

    // all-zero costs
    send(rand_coef(), '0);

    // R4: change only edge 2's input
    c = rand_coef();
    m = rand_msg();
    send(c, m);
    o_a = msg_o;
    m[2*VW +: VW] = ~m[2*VW +: VW];
    send(c, m);
    check("R4", "edge2 own input", TW'(msg_o[2*VW +: VW]), TW'(o_a[2*VW +: VW]));

    // R7: outputs hold while inputs move
    snap = msg_o;
    repeat (4) begin
      @(negedge clk);
      msg_i  = rand_msg();
      coef_i = rand_coef();
    end
    @(negedge clk);
    check("R7", "hold", msg_o, snap);

    // random patterns, with R8 floor check
    for (int t = 0; t < 20; t++) begin
      c = rand_coef();
      m = rand_msg();
      if (t % 4 == 1) for (int i = 0; i < TW / W; i++) m[i*W +: W] = m[i*W +: W] & 8'h0f;
      send(c, m);
      for (int n = 0; n < DEG; n++) begin
        logic [W-1:0] fl, mn, omn;
        fl = '0;
        for (int k = 0; k < DEG; k++) if (k != n) begin
          mn = '1;
          for (int i = 0; i < 4; i++) if (m[k*VW + i*W +: W] < mn) mn = m[k*VW + i*W +: W];
          if (mn > fl) fl = mn;
        end
        omn = '1;
        for (int i = 0; i < 4; i++) if (msg_o[n*VW + i*W +: W] < omn) omn = msg_o[n*VW + i*W +: W];
        check("R8", $sformatf("floor edge %0d", n), TW'(omn), TW'(fl));
      end
    end

    repeat (3) @(negedge clk);
    check("R2", "queue drained", TW'(exp_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule